// File: doc/BRIEF.md
# Protected-Mode Segment Register Load Checker

This block takes a 16-bit selector that a CPU wants to place in one of its data segment registers or in its stack segment register, and decides whether the load may happen. In protected mode it finds the 8-byte descriptor in the global or local table and reads its three words through a simple word memory port. It then applies the type, privilege, presence and limit rules. The result is either a fault, given as a vector and a 16-bit error code, or a completed load. A completed load writes the descriptor back with its accessed bit set and presents the cached selector, base, limit and rights. In real mode the block skips every check and loads the selector at once, with the base equal to the selector times 16.

The CPU's sequencer pulses `start` with the operands. It waits for `done`, which comes with exactly one of `fault_valid` or `load_ok`. Memory reads have a latency of one cycle: data requested while `mem_rd` is high appears on `mem_rdata` in the following cycle.

Top module: `seg_load_checker`

## Requirements
- R1: Selector bit 2 picks the table (0 = global, 1 = local). The descriptor lies at the table base plus the index (bits 15..3) times 8. If that byte offset plus 7 exceeds the table limit, the block raises the caller's fault vector (`given_vec`) without touching memory. The error code of every caller-vector fault is the selector with bit 1 cleared and bit 0 replaced by `ext_bit`.
- R2: Loading a data register (`is_stack`=0) in protected mode with selector bits 15..2 all zero completes with `load_ok`, clears the cached selector, base, limit and rights, drops `seg_valid`, and raises no fault.
- R3: The rights byte is the high byte of descriptor word 2: bit 7 present, bits 6..5 DPL, bit 4 segment (0 = system), bit 3 code, bit 2 conforming/expand-down, bit 1 readable/writable, bit 0 accessed. The caller's vector is raised for any system descriptor, for a stack load of a code or non-writable segment, and for a data load of an execute-only code segment.
- R4: A stack load raises the caller's vector when the selector is null, when DPL differs from CPL, or when RPL (selector bits 1..0) differs from CPL.
- R5: A data load raises the caller's vector when DPL is less than the larger of CPL and RPL, unless the segment is conforming code.
- R6: When the segment is not present, a stack load raises `STACK_VEC` and a data load raises `NP_VEC`. Both use the selector-based error code.
- R7: If offset+size is nonzero, a code or expand-up data segment faults when offset+size-1 exceeds the limit (word 0).
- R8: An expand-down data segment faults when offset is less than or equal to the limit, or when offset+size-1 exceeds 0xFFFF.
- R9: For a stack load a limit fault raises `STACK_VEC` with error code equal to `ext_bit` alone. For a data load it raises the caller's vector.
- R10: On success the block writes descriptor word 2 back with bit 8 set. It loads the selector, the 24-bit base ({low byte of word 2, word 1}), the limit and the rights (accessed bit set), and sets `seg_valid`.
- R11: With `prot_mode`=0 the block completes without memory access, loads the selector, sets the base to selector<<4 and sets `seg_valid`. The limit and rights keep their previous values.
- R12: `done` is a one-cycle pulse with exactly one of `fault_valid`/`load_ok`. Fault checks follow a fixed priority: table validity, type, privilege, presence, limit. A fault leaves the cached outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a load (accepted when idle) |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| is_stack | input | 1 | Target is the stack segment register |
| selector | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| given_vec | input | 8 | Fault vector used for general rule violations |
| ext_bit | input | 1 | External-event bit placed in error code bit 0 |
| acc_offset | input | 16 | Offset of the intended access |
| acc_size | input | SZW | Size in bytes of the intended access (0 = no limit test) |
| gdt_base | input | AW | Global table byte base |
| gdt_limit | input | 16 | Global table limit |
| ldt_base | input | AW | Local table byte base |
| ldt_limit | input | 16 | Local table limit |
| mem_rd | output | 1 | Word read request |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Completion pulse |
| fault_valid | output | 1 | Load refused |
| fault_vec | output | 8 | Fault vector |
| fault_err | output | 16 | Fault error code |
| load_ok | output | 1 | Load completed |
| seg_valid | output | 1 | Cached register is valid |
| seg_sel | output | 16 | Cached selector |
| seg_base | output | 24 | Cached base |
| seg_limit | output | 16 | Cached limit |
| seg_rights | output | 8 | Cached rights byte |

## Verification
The bench builds the block with AW=24 and SZW=4. It places a six-entry global table and a three-entry local table in a 512-byte word memory, so the table-limit boundary sits one entry past the last valid index of each table. With these settings it can sweep all 256 rights bytes against every CPL and RPL for both register kinds. It also crosses code, expand-up and expand-down segments with limits and offsets at 0, 0xF..0x11 and 0xFFF0..0xFFFF and sizes from 0 to 4. This covers the wrap past 0xFFFF and the zero-size bypass of the limit test.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_EVAL, ST_WB
  } ld_state_e;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       seg_kind;   // 1 = code/data segment, 0 = system
    logic       is_code;
    logic       conf_xd;    // conforming (code) or expand-down (data)
    logic       rd_wr;      // readable (code) or writable (data)
    logic       accessed;
  } rights_t;

  function automatic logic [1:0] f_pmax(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  // Byte offset of the entry plus 7 must stay within the table limit.
  function automatic logic f_entry_fits(input logic [15:0] sel, input logic [15:0] tlim);
    return {1'b0, sel[15:3], 3'b111} <= {1'b0, tlim};
  endfunction

  function automatic logic [15:0] f_sel_err(input logic [15:0] sel, input logic ext);
    return {sel[15:2], 1'b0, ext};
  endfunction

  // Limit rule for an access of size bytes at off.
  function automatic logic f_span_bad(input rights_t r, input logic [15:0] off,
                                      input logic [15:0] size, input logic [15:0] lim);
    logic [16:0] tot;
    logic [16:0] last;
    tot  = {1'b0, off} + {1'b0, size};
    last = tot - 17'd1;
    if (tot == 17'd0) return 1'b0;
    if (r.is_code || !r.conf_xd) return last > {1'b0, lim};
    return (off <= lim) || (last > 17'h0FFFF);
  endfunction

endpackage

// File: rtl/seg_locator.sv
module seg_locator #(
  parameter int AW = 24
) (
  input  logic [15:0]   sel,
  input  logic [AW-1:0] gdt_base,
  input  logic [15:0]   gdt_limit,
  input  logic [AW-1:0] ldt_base,
  input  logic [15:0]   ldt_limit,
  output logic [AW-1:0] desc_addr,
  output logic          entry_ok
);
  import seg_chk_pkg::*;

  localparam int PADW = AW - 16;

  logic [AW-1:0] tbl_base;
  logic [15:0]   tbl_lim;

  assign tbl_base  = sel[2] ? ldt_base  : gdt_base;
  assign tbl_lim   = sel[2] ? ldt_limit : gdt_limit;
  assign desc_addr = tbl_base + {{PADW{1'b0}}, sel[15:3], 3'b000};
  assign entry_ok  = f_entry_fits(sel, tbl_lim);

endmodule

// File: rtl/seg_rules.sv
module seg_rules #(
  parameter logic [7:0] STACK_VEC = 8'd12,
  parameter logic [7:0] NP_VEC    = 8'd11
) (
  input  logic        is_stack,
  input  logic [15:0] sel,
  input  logic [1:0]  cpl,
  input  logic        ext,
  input  logic [7:0]  given_vec,
  input  logic [7:0]  rights,
  input  logic [15:0] lim,
  input  logic [15:0] off,
  input  logic [15:0] size,
  output logic        type_bad,
  output logic        priv_bad,
  output logic        pres_bad,
  output logic        span_bad,
  output logic        flt,
  output logic [7:0]  vec,
  output logic [15:0] err
);
  import seg_chk_pkg::*;

  rights_t    r;
  logic [1:0] rpl;
  logic [15:0] sel_err;

  assign r       = rights_t'(rights);
  assign rpl     = sel[1:0];
  assign sel_err = f_sel_err(sel, ext);

  assign type_bad = !r.seg_kind ||
                    (is_stack ? (r.is_code || !r.rd_wr) : (r.is_code && !r.rd_wr));
  assign priv_bad = is_stack ? ((r.dpl != cpl) || (rpl != cpl))
                             : (!(r.is_code && r.conf_xd) && (r.dpl < f_pmax(cpl, rpl)));
  assign pres_bad = !r.present;
  assign span_bad = f_span_bad(r, off, size, lim);

  always_comb begin
    flt = 1'b1;
    vec = given_vec;
    err = sel_err;
    if (type_bad || priv_bad) begin
      vec = given_vec;
    end else if (pres_bad) begin
      vec = is_stack ? STACK_VEC : NP_VEC;
    end else if (span_bad) begin
      vec = is_stack ? STACK_VEC : given_vec;
      err = is_stack ? {15'd0, ext} : sel_err;
    end else begin
      flt = 1'b0;
    end
  end

endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker #(
  parameter int         AW        = 24,
  parameter int         SZW       = 4,
  parameter logic [7:0] STACK_VEC = 8'd12,
  parameter logic [7:0] NP_VEC    = 8'd11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           prot_mode,
  input  logic           is_stack,
  input  logic [15:0]    selector,
  input  logic [1:0]     cpl,
  input  logic [7:0]     given_vec,
  input  logic           ext_bit,
  input  logic [15:0]    acc_offset,
  input  logic [SZW-1:0] acc_size,
  input  logic [AW-1:0]  gdt_base,
  input  logic [15:0]    gdt_limit,
  input  logic [AW-1:0]  ldt_base,
  input  logic [15:0]    ldt_limit,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata,
  output logic           done,
  output logic           fault_valid,
  output logic [7:0]     fault_vec,
  output logic [15:0]    fault_err,
  output logic           load_ok,
  output logic           seg_valid,
  output logic [15:0]    seg_sel,
  output logic [23:0]    seg_base,
  output logic [15:0]    seg_limit,
  output logic [7:0]     seg_rights
);
  import seg_chk_pkg::*;

  localparam int SZPAD = 16 - SZW;

  ld_state_e     state;
  logic          stk_q, ext_q;
  logic [15:0]   sel_q, off_q, size_q;
  logic [1:0]    cpl_q;
  logic [7:0]    gvec_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   w0_q, w1_q, w2_q;

  // Named internal events
  logic          sel_is_null;
  logic [AW-1:0] loc_addr;
  logic          loc_ok;
  logic          rule_type, rule_priv, rule_pres, rule_span, rule_flt;
  logic [7:0]    rule_vec;
  logic [15:0]   rule_err;

  assign sel_is_null = (selector[15:2] == 14'd0);

  seg_locator #(.AW(AW)) u_loc (
    .sel(selector), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .ldt_base(ldt_base), .ldt_limit(ldt_limit),
    .desc_addr(loc_addr), .entry_ok(loc_ok)
  );

  seg_rules #(.STACK_VEC(STACK_VEC), .NP_VEC(NP_VEC)) u_rules (
    .is_stack(stk_q), .sel(sel_q), .cpl(cpl_q), .ext(ext_q), .given_vec(gvec_q),
    .rights(mem_rdata[15:8]), .lim(w0_q), .off(off_q), .size(size_q),
    .type_bad(rule_type), .priv_bad(rule_priv), .pres_bad(rule_pres), .span_bad(rule_span),
    .flt(rule_flt), .vec(rule_vec), .err(rule_err)
  );

  // Memory port
  always_comb begin
    mem_rd    = (state == ST_RD0) || (state == ST_RD1) || (state == ST_RD2);
    mem_wr    = (state == ST_WB);
    mem_wdata = w2_q | 16'h0100;
    case (state)
      ST_RD1:       mem_addr = addr_q + AW'(2);
      ST_RD2, ST_WB: mem_addr = addr_q + AW'(4);
      default:      mem_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      stk_q <= 1'b0; ext_q <= 1'b0; sel_q <= '0; off_q <= '0; size_q <= '0;
      cpl_q <= '0; gvec_q <= '0; addr_q <= '0;
      w0_q <= '0; w1_q <= '0; w2_q <= '0;
      done <= 1'b0; fault_valid <= 1'b0; fault_vec <= '0; fault_err <= '0; load_ok <= 1'b0;
      seg_valid <= 1'b0; seg_sel <= '0; seg_base <= '0; seg_limit <= '0; seg_rights <= '0;
    end else begin
      done        <= 1'b0;
      fault_valid <= 1'b0;
      load_ok     <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          stk_q  <= is_stack;   ext_q  <= ext_bit;   sel_q <= selector;
          off_q  <= acc_offset; size_q <= {{SZPAD{1'b0}}, acc_size};
          cpl_q  <= cpl;        gvec_q <= given_vec; addr_q <= loc_addr;
          if (!prot_mode) begin
            seg_sel <= selector; seg_base <= {4'd0, selector, 4'd0};
            seg_valid <= 1'b1; done <= 1'b1; load_ok <= 1'b1;
          end else if (sel_is_null && !is_stack) begin
            seg_sel <= '0; seg_base <= '0; seg_limit <= '0; seg_rights <= '0;
            seg_valid <= 1'b0; done <= 1'b1; load_ok <= 1'b1;
          end else if (sel_is_null || !loc_ok) begin
            done <= 1'b1; fault_valid <= 1'b1;
            fault_vec <= given_vec; fault_err <= f_sel_err(selector, ext_bit);
          end else begin
            state <= ST_RD0;
          end
        end
        ST_RD0: state <= ST_RD1;
        ST_RD1: begin w0_q <= mem_rdata; state <= ST_RD2; end
        ST_RD2: begin w1_q <= mem_rdata; state <= ST_EVAL; end
        ST_EVAL: begin
          w2_q <= mem_rdata;
          if (rule_flt) begin
            done <= 1'b1; fault_valid <= 1'b1;
            fault_vec <= rule_vec; fault_err <= rule_err;
            state <= ST_IDLE;
          end else begin
            state <= ST_WB;
          end
        end
        ST_WB: begin
          seg_sel    <= sel_q;
          seg_base   <= {w2_q[7:0], w1_q};
          seg_limit  <= w0_q;
          seg_rights <= w2_q[15:8] | 8'h01;
          seg_valid  <= 1'b1; done <= 1'b1; load_ok <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- Assertions ----------------
  a_r12_done_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault_valid != load_ok));

  a_r12_fault_holds_cache: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> ($stable(seg_valid) && $stable(seg_sel) && $stable(seg_base)));

  a_r1_bad_entry_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && prot_mode && !sel_is_null && !loc_ok)
      |=> (fault_valid && fault_vec == $past(given_vec) && !mem_rd));

  a_r6_stack_not_present: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVAL && stk_q && rule_pres && !rule_type && !rule_priv)
      |=> (fault_valid && fault_vec == STACK_VEC && fault_err == {sel_q[15:2], 1'b0, ext_q}));

  a_r10_writeback_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[8]);

  a_r10_writeback_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (load_ok && seg_valid && seg_rights[0]));

  a_r2_null_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && !seg_valid) |-> (seg_base == 24'd0 && seg_rights == 8'd0 && seg_sel == 16'd0));

  a_r11_real_mode_base: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !prot_mode)
      |=> (load_ok && seg_valid && seg_base == {4'd0, $past(selector), 4'd0}));

endmodule

// File: tb/tb_seg_load_checker.sv
`timescale 1ns/1ps
module tb_seg_load_checker;
  localparam int AW = 24;
  localparam int SZW = 4;
  localparam logic [7:0] GV = 8'd13, SV = 8'd12, NV = 8'd11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, prot_mode = 1, is_stack = 0, ext_bit = 0;
  logic [15:0] selector = 0, acc_offset = 0;
  logic [1:0]  cpl = 0;
  logic [SZW-1:0] acc_size = 0;
  logic [AW-1:0] gdt_base = 24'h40, ldt_base = 24'h100;
  logic [15:0] gdt_limit = 16'h002F, ldt_limit = 16'h0017;
  logic mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic done, fault_valid, load_ok, seg_valid;
  logic [7:0] fault_vec, seg_rights;
  logic [15:0] fault_err, seg_sel, seg_limit;
  logic [23:0] seg_base;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  seg_load_checker #(.AW(AW), .SZW(SZW), .STACK_VEC(SV), .NP_VEC(NV)) dut (
    .clk, .rst_n, .start, .prot_mode, .is_stack, .selector, .cpl, .given_vec(GV),
    .ext_bit, .acc_offset, .acc_size, .gdt_base, .gdt_limit, .ldt_base, .ldt_limit,
    .mem_rd, .mem_wr, .mem_addr, .mem_wdata, .mem_rdata, .done, .fault_valid,
    .fault_vec, .fault_err, .load_ok, .seg_valid, .seg_sel, .seg_base, .seg_limit, .seg_rights
  );

  // Word memory, one-cycle read latency
  logic [15:0] mem [0:255];
  logic tb_we = 0;
  logic [7:0] tb_idx = 0;
  logic [15:0] tb_dat = 0;
  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_dat;
    else if (mem_wr) mem[mem_addr[8:1]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[8:1]];
  end

  task automatic mem_put(input logic [7:0] i, input logic [15:0] d);
    tb_idx = i; tb_dat = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic check(input logic ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Captured results
  logic r_done, r_flt, r_ok, r_val;
  logic [7:0] r_vec, r_rights;
  logic [15:0] r_err, r_sel, r_lim;
  logic [23:0] r_base;

  task automatic run_load(input logic pm, input logic stk, input logic [15:0] sel,
                          input logic [1:0] c, input logic x,
                          input logic [15:0] off, input logic [SZW-1:0] sz);
    int n;
    prot_mode = pm; is_stack = stk; selector = sel; cpl = c; ext_bit = x;
    acc_offset = off; acc_size = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 30) begin @(negedge clk); n++; end
    r_done = done; r_flt = fault_valid; r_ok = load_ok; r_val = seg_valid;
    r_vec = fault_vec; r_err = fault_err; r_sel = seg_sel; r_base = seg_base;
    r_lim = seg_limit; r_rights = seg_rights;
  endtask

  // Reference rules, written from the requirements
  task automatic model(input logic stk, input logic [15:0] sel, input logic [1:0] c,
                       input logic x, input logic [7:0] r, input logic [15:0] off,
                       input int sz, input logic [15:0] lim,
                       output logic f, output logic [7:0] v, output logic [15:0] e,
                       output string tag);
    logic pr, sg, cd, ce, rw;
    int dpl, rpl, hi, total;
    logic bad;
    pr = r[7]; dpl = int'(r[6:5]); sg = r[4]; cd = r[3]; ce = r[2]; rw = r[1];
    rpl = int'(sel[1:0]);
    hi = (int'(c) > rpl) ? int'(c) : rpl;
    f = 1'b1; v = GV; e = (sel & 16'hFFFC) | {15'd0, x}; tag = "none";
    if (!sg) tag = "R3";
    else if (stk && (cd || !rw)) tag = "R3";
    else if (!stk && cd && !rw) tag = "R3";
    else if (stk && (dpl != int'(c) || rpl != int'(c))) tag = "R4";
    else if (!stk && !(cd && ce) && dpl < hi) tag = "R5";
    else if (!pr) begin tag = "R6"; v = stk ? SV : NV; end
    else begin
      total = int'(off) + sz;
      bad = 1'b0;
      if (total != 0) begin
        if (cd || !ce) bad = (total - 1) > int'(lim);
        else bad = (int'(off) <= int'(lim)) || ((total - 1) > 65535);
      end
      if (bad) begin
        tag = stk ? "R9" : ((!cd && ce) ? "R8" : "R7");
        if (stk) begin v = SV; e = {15'd0, x}; end
      end else begin
        f = 1'b0;
      end
    end
  endtask

  task automatic judge(input logic stk, input logic [15:0] sel, input logic [1:0] c,
                       input logic x, input logic [7:0] r, input logic [15:0] off,
                       input int sz, input logic [15:0] lim, input logic [7:0] w2i,
                       input logic [23:0] ebase);
    logic ef; logic [7:0] ev; logic [15:0] ee; string tg;
    model(stk, sel, c, x, r, off, sz, lim, ef, ev, ee, tg);
    if (ef) begin
      check(r_done && r_flt && !r_ok && r_vec == ev && r_err == ee, tg,
            {r_done, r_flt, r_ok, r_vec, r_err}, {3'b110, ev, ee});
    end else begin
      check(r_done && r_ok && !r_flt && r_val && r_sel == sel && r_base == ebase &&
            r_lim == lim && r_rights == (r | 8'h01), "R10",
            {r_ok, r_val, r_sel, r_base, r_rights}, {2'b11, sel, ebase, r | 8'h01});
      check(mem[w2i] == {r | 8'h01, 8'h5A}, "R10 writeback", mem[w2i], {r | 8'h01, 8'h5A});
    end
  endtask

  localparam logic [15:0] LIMS [4] = '{16'h0000, 16'h0010, 16'hFFF0, 16'hFFFF};
  localparam logic [15:0] OFFS [8] = '{16'h0000, 16'h0001, 16'h000F, 16'h0010,
                                       16'h0011, 16'hFFF0, 16'hFFFE, 16'hFFFF};
  localparam logic [7:0]  KINDS [3] = '{8'h93, 8'h97, 8'h9B};

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !seg_valid && !mem_rd && !mem_wr, "R12 reset",
          {done, seg_valid, mem_rd, mem_wr}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // GDT entry 2 at byte 0x50 -> words 0x28..0x2A
    mem_put(8'h28, 16'h1234);
    mem_put(8'h29, 16'hABCD);

    // Sweep rights x CPL x RPL x register kind (R3..R6, R10)
    for (int rr = 0; rr < 256; rr++)
      for (int c = 0; c < 4; c++)
        for (int rp = 0; rp < 4; rp++)
          for (int stk = 0; stk < 2; stk++) begin
            logic [15:0] sel;
            logic x;
            sel = 16'h0010 | 16'(rp);
            x = rr[0] ^ c[0];
            mem_put(8'h2A, {rr[7:0], 8'h5A});
            run_load(1'b1, stk[0], sel, c[1:0], x, 16'h0, '0);
            judge(stk[0], sel, c[1:0], x, rr[7:0], 16'h0, 0, 16'h1234, 8'h2A, 24'h5AABCD);
          end

    // Limit sweep (R7, R8, R9)
    for (int k = 0; k < 3; k++)
      for (int li = 0; li < 4; li++)
        for (int oi = 0; oi < 8; oi++)
          for (int sz = 0; sz < 5; sz++)
            for (int stk = 0; stk < 2; stk++) begin
              mem_put(8'h28, LIMS[li]);
              mem_put(8'h2A, {KINDS[k], 8'h5A});
              run_load(1'b1, stk[0], 16'h0010, 2'd0, 1'b1, OFFS[oi], SZW'(sz));
              judge(stk[0], 16'h0010, 2'd0, 1'b1, KINDS[k], OFFS[oi], sz, LIMS[li],
                    8'h2A, 24'h5AABCD);
            end

    // R1: last global entry (index 5, words 0x34..0x36) is reachable
    mem_put(8'h34, 16'h00FF); mem_put(8'h35, 16'h2222); mem_put(8'h36, 16'h9303);
    run_load(1'b1, 1'b0, 16'h0028, 2'd0, 1'b0, 16'h0, '0);
    check(r_ok && r_base == 24'h032222 && r_lim == 16'h00FF, "R1 last gdt entry",
          {r_ok, r_base, r_lim}, {1'b1, 24'h032222, 16'h00FF});
    // R1: global index 6 beyond the limit
    run_load(1'b1, 1'b0, 16'h0031, 2'd0, 1'b1, 16'h0, '0);
    check(r_flt && r_vec == GV && r_err == 16'h0031, "R1 gdt limit",
          {r_flt, r_vec, r_err}, {1'b1, GV, 16'h0031});
    // R12: fault keeps the cached register
    check(r_sel == 16'h0028 && r_base == 24'h032222 && r_val, "R12 cache kept",
          {r_sel, r_base}, {16'h0028, 24'h032222});
    @(negedge clk);
    check(!done, "R12 single pulse", done, 1'b0);
    // R1: local entry 2 at byte 0x110 -> words 0x88..0x8A
    mem_put(8'h88, 16'h0777); mem_put(8'h89, 16'h3456); mem_put(8'h8A, 16'h9201);
    run_load(1'b1, 1'b0, 16'h0014, 2'd0, 1'b0, 16'h0, '0);
    check(r_ok && r_base == 24'h013456 && r_lim == 16'h0777 && r_rights == 8'h93,
          "R1 ldt entry", {r_ok, r_base, r_lim, r_rights}, {1'b1, 24'h013456, 16'h0777, 8'h93});
    // R1: local index 3 beyond the limit
    run_load(1'b1, 1'b0, 16'h001C, 2'd0, 1'b1, 16'h0, '0);
    check(r_flt && r_vec == GV && r_err == 16'h001D, "R1 ldt limit",
          {r_flt, r_vec, r_err}, {1'b1, GV, 16'h001D});

    // R2: null data selector with RPL 3
    run_load(1'b1, 1'b0, 16'h0003, 2'd0, 1'b0, 16'h0, '0);
    check(r_ok && !r_flt && !r_val && r_sel == 0 && r_base == 0 && r_lim == 0 && r_rights == 0,
          "R2 null data", {r_ok, r_val, r_sel, r_base, r_lim}, {1'b1, 1'b0, 16'h0, 24'h0, 16'h0});

    // R4: null stack selector
    run_load(1'b1, 1'b1, 16'h0002, 2'd2, 1'b1, 16'h0, '0);
    check(r_flt && r_vec == GV && r_err == 16'h0001, "R4 null stack",
          {r_flt, r_vec, r_err}, {1'b1, GV, 16'h0001});

    // R11: real mode
    run_load(1'b0, 1'b0, 16'h1234, 2'd0, 1'b0, 16'h0, '0);
    check(r_ok && r_val && r_sel == 16'h1234 && r_base == 24'h012340 && r_lim == 16'h0 &&
          r_rights == 8'h0, "R11 real mode", {r_ok, r_val, r_base, r_lim},
          {1'b1, 1'b1, 24'h012340, 16'h0});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule